// File: doc/BRIEF.md
# Dual-Bank Output Gamma Lookup

This block applies an output transfer curve to each colour channel of a pixel writeback path. Every channel has its own piecewise-linear curve. The curve is held as a table of equally spaced points, and there are two complete copies of the tables, called bank A and bank B. The pixel path reads from one bank. Software can load the other bank at the same time. At the next frame boundary software switches the pixel path over to the bank it has just loaded.

Software loads a table through a small write port:

- a target-bank bit selects which bank receives the writes;
- a three-bit channel mask selects which channels receive each word;
- an index load sets the write pointer;
- each data strobe stores one word and advances the pointer by one.

A channel table with N segments holds N+1 points. The extra last point is the end value of the final segment.

The pixel path splits each input sample into an upper field and a lower field. The upper field addresses a point in the table. The lower field is the fraction used to interpolate between that point and the next one. The mode and bank requested by software are sampled only at a frame-start strobe. Read-only status outputs report the mode and bank that are in effect.

Top module: `ogam_dual_bank`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0, `cur_mode` is 0 and `cur_bank` is 0, the write pointer is 0, and every table entry in both banks is 0.
- R2: A requested mode of 2 selects table lookup. The values 0, 1 and 3 all give bypass. `cur_mode` reports 2 for lookup and 0 for bypass, and never reports 1 or 3.
- R3: A bank-select value of 0 makes the pixel path read bank A. A value of 1 makes it read bank B. `cur_bank` reports the bank in use.
- R4: `cur_mode` and `cur_bank` change only on the clock edge where `frame_start` is high. On that edge they take the requested values. A pixel sampled on that same edge still uses the previous values.
- R5: `host_bank` (0 = A, 1 = B) selects the bank that receives data writes. It does not depend on the bank the pixel path is using. Writes to the inactive bank leave the pixel output unchanged.
- R6: The write mask decodes as follows: bit 2 enables red, bit 1 enables green and bit 0 enables blue. A mask of 7 stores the same word into all three channels.
- R7: `idx_wr` loads `idx_val` into the write pointer. Each `data_wr` stores `data_val` at the current pointer and then advances the pointer by one, wrapping modulo 2^(ADDR_W+1). When `idx_wr` and `data_wr` are high together, the data goes to the old pointer and the pointer takes `idx_val`.
- R8: Each channel holds 2^ADDR_W+1 entries, at indices 0 to 2^ADDR_W. A data write made while the pointer is above 2^ADDR_W is dropped, but the pointer still advances.
- R9: `out_valid` and the output samples appear exactly 3 clock cycles after the input sample is taken.
- R10: In bypass, each output channel equals its input channel unchanged.
- R11: In lookup mode, each channel uses its own point index i = in[DATA_W-1:FRAC_W] and fraction f = in[FRAC_W-1:0], with FRAC_W = DATA_W-ADDR_W. The output is e[i] + floor(((e[i+1]-e[i])*f + 2^(FRAC_W-1)) / 2^FRAC_W), clamped to the range 0 to 2^DATA_W-1.
- R12: Writes to the bank the pixel path is using are accepted. They affect any pixel sampled on a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Requested mode (2 = lookup, others = bypass) |
| cfg_bank_sel | input | 1 | Requested bank for the pixel path (0 = A, 1 = B) |
| frame_start | input | 1 | Frame boundary strobe; applies the requested mode and bank |
| host_bank | input | 1 | Bank that receives data writes |
| wr_mask | input | 3 | Channel enables for data writes {red, green, blue} |
| idx_wr | input | 1 | Load strobe for the write pointer |
| idx_val | input | ADDR_W+1 | New write pointer value |
| data_wr | input | 1 | Data write strobe |
| data_val | input | DATA_W | Table word to store |
| cur_mode | output | 2 | Mode in effect (0 or 2) |
| cur_bank | output | 1 | Bank in effect |
| pix_valid | input | 1 | Input sample valid |
| pix_r | input | DATA_W | Input red |
| pix_g | input | DATA_W | Input green |
| pix_b | input | DATA_W | Input blue |
| out_valid | output | 1 | Output sample valid |
| out_r | output | DATA_W | Output red |
| out_g | output | DATA_W | Output green |
| out_b | output | DATA_W | Output blue |

## Verification
The embedded properties are checked on every cycle and cover four things:

- the three-cycle valid latency;
- unchanged data in bypass;
- the status outputs holding between frame strobes and staying on legal encodings;
- the write pointer stepping by one on each data write.

The interpolated values, the channel-mask decode, the bank steering, the dropping of writes beyond the last entry, and the isolation of the inactive bank are shown only by the bench's scenarios. In those scenarios a reference model tracks every table entry and compares each output word on every cycle.

// File: rtl/ogam_pkg.sv
package ogam_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_LUT    = 2'd2
  } ogam_mode_e;

  localparam int NUM_CH = 3;
  // channel index c is enabled by write-mask bit (NUM_CH-1-c): red=2, green=1, blue=0
  function automatic int mask_bit(input int ch);
    return NUM_CH - 1 - ch;
  endfunction
endpackage

// File: rtl/ogam_frame_ctl.sv
module ogam_frame_ctl
  import ogam_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_bank_sel,
  input  logic       frame_start,
  output logic [1:0] cur_mode,
  output logic       cur_bank
);
  logic [1:0] mode_norm;
  assign mode_norm = (cfg_mode == MODE_LUT) ? MODE_LUT : MODE_BYPASS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_mode <= MODE_BYPASS;
      cur_bank <= 1'b0;
    end else if (frame_start) begin
      cur_mode <= mode_norm;
      cur_bank <= cfg_bank_sel;
    end
  end

  // R4: status holds between frame strobes
  p_hold_between_frames_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(cur_mode) && $stable(cur_bank)));
  // R2: reported mode is only ever bypass or lookup
  p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_BYPASS) || (cur_mode == MODE_LUT));
endmodule

// File: rtl/ogam_bank_store.sv
module ogam_bank_store
  import ogam_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              host_bank,
  input  logic [2:0]                        wr_mask,
  input  logic                              idx_wr,
  input  logic [ADDR_W:0]                   idx_val,
  input  logic                              data_wr,
  input  logic [DATA_W-1:0]                 data_val,
  input  logic                              rd_bank,
  input  logic [NUM_CH-1:0][ADDR_W-1:0]     rd_addr,
  output logic [NUM_CH-1:0][DATA_W-1:0]     rd_base,
  output logic [NUM_CH-1:0][DATA_W-1:0]     rd_next
);
  localparam int ENTRIES = (1 << ADDR_W) + 1;
  localparam int PTR_W   = ADDR_W + 1;
  localparam int NBANK   = 2;

  logic [PTR_W-1:0] wr_ptr;
  logic             ptr_in_range;
  logic             wr_accept;
  logic [NBANK-1:0][NUM_CH-1:0][DATA_W-1:0] base_bk, next_bk;

  assign ptr_in_range = (int'(wr_ptr) < ENTRIES);
  assign wr_accept    = data_wr && ptr_in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_ptr <= '0;
    else if (idx_wr)  wr_ptr <= idx_val;
    else if (data_wr) wr_ptr <= wr_ptr + PTR_W'(1);
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [DATA_W-1:0] ent [ENTRIES];
      logic              hit;
      assign hit = wr_accept && (host_bank == b[0]) && wr_mask[mask_bit(c)];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
        end else if (hit) begin
          ent[wr_ptr[PTR_W-1:0]] <= data_val;
        end
      end

      assign base_bk[b][c] = ent[{1'b0, rd_addr[c]}];
      assign next_bk[b][c] = ent[{1'b0, rd_addr[c]} + PTR_W'(1)];
    end
  end

  assign rd_base = base_bk[rd_bank];
  assign rd_next = next_bk[rd_bank];

  // R7: each data write without an index load moves the pointer by one
  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !idx_wr) |=> (wr_ptr == $past(wr_ptr) + PTR_W'(1)));
  // R7: index load sets the pointer
  p_ptr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (wr_ptr == $past(idx_val)));
endmodule

// File: rtl/ogam_interp_pipe.sv
module ogam_interp_pipe
  import ogam_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          use_lut,
  input  logic [NUM_CH-1:0][DATA_W-1:0] in_pix,
  input  logic [NUM_CH-1:0][DATA_W-1:0] lut_base,
  input  logic [NUM_CH-1:0][DATA_W-1:0] lut_next,
  output logic                          out_valid,
  output logic [NUM_CH-1:0][DATA_W-1:0] out_pix
);
  localparam int FRAC_W = DATA_W - ADDR_W;
  localparam int DIFF_W = DATA_W + 1;
  localparam int PROD_W = DATA_W + FRAC_W + 2;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [PROD_W-1:0] VMAX = PROD_W'((1 << DATA_W) - 1);

  function automatic logic signed [PROD_W-1:0] slope_mul(
      input logic signed [DIFF_W-1:0] d, input logic [FRAC_W-1:0] f);
    return PROD_W'(d) * $signed({1'b0, f});
  endfunction

  function automatic logic [DATA_W-1:0] round_add_clamp(
      input logic [DATA_W-1:0] base, input logic signed [PROD_W-1:0] prod);
    logic signed [PROD_W-1:0] adj, sum;
    adj = (prod + HALF) >>> FRAC_W;
    sum = $signed({{(PROD_W-DATA_W){1'b0}}, base}) + adj;
    if (sum < 0)         return '0;
    else if (sum > VMAX) return VMAX[DATA_W-1:0];
    else                 return sum[DATA_W-1:0];
  endfunction

  logic s1_v, s2_v, s1_lut, s2_lut;
  logic [NUM_CH-1:0][DATA_W-1:0] s1_raw, s2_raw, s1_base, s2_base;
  logic [NUM_CH-1:0][FRAC_W-1:0] s1_frac;
  logic signed [DIFF_W-1:0]      s1_diff [NUM_CH];
  logic signed [PROD_W-1:0]      s2_prod [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s2_v <= 1'b0; out_valid <= 1'b0;
      s1_lut <= 1'b0; s2_lut <= 1'b0;
    end else begin
      s1_v <= in_valid;  s1_lut <= use_lut;
      s2_v <= s1_v;      s2_lut <= s1_lut;
      out_valid <= s2_v;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_raw[c] <= '0; s1_base[c] <= '0; s1_frac[c] <= '0; s1_diff[c] <= '0;
        s2_raw[c] <= '0; s2_base[c] <= '0; s2_prod[c] <= '0;
        out_pix[c] <= '0;
      end else begin
        s1_raw[c]  <= in_pix[c];
        s1_base[c] <= lut_base[c];
        s1_frac[c] <= in_pix[c][FRAC_W-1:0];
        s1_diff[c] <= $signed({1'b0, lut_next[c]}) - $signed({1'b0, lut_base[c]});
        s2_raw[c]  <= s1_raw[c];
        s2_base[c] <= s1_base[c];
        s2_prod[c] <= slope_mul(s1_diff[c], s1_frac[c]);
        out_pix[c] <= s2_lut ? round_add_clamp(s2_base[c], s2_prod[c]) : s2_raw[c];
      end
    end
  end

  // R9: fixed three-cycle latency of the valid flag
  p_valid_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);
  p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);
  // R10: bypass returns the sample untouched
  p_bypass_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_lut) |-> ##3 (out_pix == $past(in_pix, 3)));
endmodule

// File: rtl/ogam_dual_bank.sv
module ogam_dual_bank
  import ogam_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_bank_sel,
  input  logic              frame_start,
  input  logic              host_bank,
  input  logic [2:0]        wr_mask,
  input  logic              idx_wr,
  input  logic [ADDR_W:0]   idx_val,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_val,
  output logic [1:0]        cur_mode,
  output logic              cur_bank,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_r,
  input  logic [DATA_W-1:0] pix_g,
  input  logic [DATA_W-1:0] pix_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_r,
  output logic [DATA_W-1:0] out_g,
  output logic [DATA_W-1:0] out_b
);
  localparam int FRAC_W = DATA_W - ADDR_W;

  logic [NUM_CH-1:0][DATA_W-1:0] in_pix, out_pix, lut_base, lut_next;
  logic [NUM_CH-1:0][ADDR_W-1:0] rd_addr;
  logic                          use_lut;

  assign in_pix  = {pix_b, pix_g, pix_r};   // index 0 = red
  assign use_lut = (cur_mode == MODE_LUT);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_addr
    assign rd_addr[c] = in_pix[c][DATA_W-1:FRAC_W];
  end

  ogam_frame_ctl u_ctl (
    .clk, .rst_n, .cfg_mode, .cfg_bank_sel, .frame_start, .cur_mode, .cur_bank
  );

  ogam_bank_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk, .rst_n, .host_bank, .wr_mask, .idx_wr, .idx_val, .data_wr, .data_val,
    .rd_bank(cur_bank), .rd_addr, .rd_base(lut_base), .rd_next(lut_next)
  );

  ogam_interp_pipe #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pipe (
    .clk, .rst_n, .in_valid(pix_valid), .use_lut, .in_pix,
    .lut_base, .lut_next, .out_valid, .out_pix
  );

  assign out_r = out_pix[0];
  assign out_g = out_pix[1];
  assign out_b = out_pix[2];
endmodule

// File: tb/ogam_dual_bank_tb.sv
module ogam_dual_bank_tb;
  localparam int DW = 10, AW = 4, FW = DW - AW, NE = (1 << AW) + 1, VMX = (1 << DW) - 1;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_mode = 0; logic cfg_bank_sel = 0, frame_start = 0, host_bank = 0;
  logic [2:0] wr_mask = 0; logic idx_wr = 0, data_wr = 0;
  logic [AW:0] idx_val = 0; logic [DW-1:0] data_val = 0;
  logic [1:0] cur_mode; logic cur_bank;
  logic pix_valid = 0; logic [DW-1:0] pix_r = 0, pix_g = 0, pix_b = 0;
  logic out_valid; logic [DW-1:0] out_r, out_g, out_b;

  always #4 clk = ~clk;   // 125 MHz

  ogam_dual_bank #(.DATA_W(DW), .ADDR_W(AW)) u_dut (.*);

  int checks = 0, fails = 0, cyc = 0;
  string req = "R1";

  // reference model
  int lut [2][3][NE];
  int mptr, mmode, mbank;
  bit ev [3];
  int ed [3][3];

  function automatic int interp(int b, int n, int x);
    int f, y;
    f = x % (1 << FW);
    y = b + (((n - b) * f + (1 << (FW - 1))) >>> FW);
    if (y < 0) y = 0;
    if (y > VMX) y = VMX;
    return y;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (lut[b, c, i]) lut[b][c][i] = 0;
      mptr = 0; mmode = 0; mbank = 0;
      foreach (ev[k]) begin ev[k] = 0; ed[k] = '{0, 0, 0}; end
    end else begin
      int px [3]; int ny [3];
      px = '{int'(pix_r), int'(pix_g), int'(pix_b)};
      for (int c = 0; c < 3; c++) begin
        if (mmode == 2) begin
          int i; i = px[c] >> FW;
          ny[c] = interp(lut[mbank][c][i], lut[mbank][c][i + 1], px[c]);
        end else ny[c] = px[c];
      end
      ev[2] = ev[1]; ed[2] = ed[1];
      ev[1] = ev[0]; ed[1] = ed[0];
      ev[0] = pix_valid; ed[0] = ny;
      if (data_wr && mptr < NE)
        for (int c = 0; c < 3; c++) if (wr_mask[2 - c]) lut[host_bank][c][mptr] = data_val;
      if (idx_wr) mptr = idx_val;
      else if (data_wr) mptr = (mptr + 1) % (1 << (AW + 1));
      if (frame_start) begin mmode = (cfg_mode == 2) ? 2 : 0; mbank = cfg_bank_sel; end
    end
  end

  task automatic chk(string r, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", r, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk("R9", out_valid, ev[2], "out_valid");
    if (ev[2]) begin
      chk(req, out_r, ed[2][0], "out_r");
      chk(req, out_g, ed[2][1], "out_g");
      chk(req, out_b, ed[2][2], "out_b");
    end
    chk("R4", cur_mode, mmode, "cur_mode");
    chk("R4", cur_bank, mbank, "cur_bank");
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  function automatic int curve(int kind, int i);
    int v;
    case (kind)
      0: v = i * 64;
      1: v = 1023 - i * 60;
      2: v = i * i * 3;
      default: v = (i * 37 + 5) % 1024;
    endcase
    return (v > VMX) ? VMX : v;
  endfunction

  task automatic set_idx(int v);
    idx_wr = 1; idx_val = v[AW:0]; @(negedge clk); idx_wr = 0;
  endtask
  task automatic wr(int bank, int mask, int v);
    host_bank = bank[0]; wr_mask = mask[2:0]; data_wr = 1; data_val = v[DW-1:0];
    @(negedge clk); data_wr = 0;
  endtask
  task automatic load(int bank, int mask, int kind);
    set_idx(0);
    for (int i = 0; i < NE; i++) wr(bank, mask, curve(kind, i));
  endtask
  task automatic frame(int mode, int sel);
    cfg_mode = mode[1:0]; cfg_bank_sel = sel[0]; frame_start = 1;
    @(negedge clk); frame_start = 0;
  endtask
  task automatic pix(int r, int g, int b);
    pix_valid = 1; pix_r = r[DW-1:0]; pix_g = g[DW-1:0]; pix_b = b[DW-1:0];
    @(negedge clk); pix_valid = 0;
  endtask
  task automatic burst(int n);
    for (int k = 0; k < n; k++) pix($urandom % 1024, $urandom % 1024, $urandom % 1024);
    pix(0, 1023, 512); pix(63, 64, 1000);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", out_valid, 0, "out_valid in reset");
    chk("R1", cur_mode, 0, "cur_mode in reset");
    chk("R1", cur_bank, 0, "cur_bank in reset");
    rst_n = 1; @(negedge clk);
    req = "R1"; frame(2, 0); burst(4);            // zero tables give zero output
    req = "R10"; frame(0, 0); burst(8);
    req = "R2"; frame(1, 0); burst(4); frame(3, 1); burst(4);
    // R6: one curve to all channels, then a distinct curve per mask bit
    req = "R6";
    load(0, 7, 0);
    load(1, 4, 1); load(1, 2, 2); load(1, 1, 3);
    // R4: request without strobe has no effect yet
    req = "R4"; cfg_mode = 2; cfg_bank_sel = 0; burst(4);
    req = "R3"; frame(2, 0); burst(16);
    req = "R11"; frame(2, 1); burst(24);
    // R5: rewrite inactive bank A while B is in use
    req = "R5"; load(0, 7, 3); burst(8);
    // R12: write into the active bank B
    req = "R12"; set_idx(3); wr(1, 7, 900); wr(1, 2, 10); burst(8);
    // R7: index reload mid-stream, and simultaneous index load plus data write
    req = "R7"; set_idx(8); wr(1, 4, 5); wr(1, 1, 1000);
    idx_wr = 1; idx_val = 1; data_wr = 1; host_bank = 1; wr_mask = 7; data_val = 777;
    @(negedge clk); idx_wr = 0; data_wr = 0;
    wr(1, 7, 44); burst(8);
    // R8: writes past the last entry are dropped, pointer still wraps
    req = "R8"; set_idx(16); wr(1, 7, 1023); wr(1, 7, 0); set_idx(20);
    for (int k = 0; k < 12; k++) wr(1, 7, 111);
    wr(1, 7, 222);   // pointer wrapped to 0
    burst(8);
    req = "R3"; frame(2, 0); burst(12);
    req = "R10"; frame(0, 1); burst(6);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule